// File: doc/BRIEF.md
# Auxiliary Blit Fetch Channel Controller

This block is an extra read channel for a 2D blitter. It walks its own rectangle of pixels and issues one memory read request for each pixel. The rectangle has its own width, height, base address and direction bits, kept apart from the destination rectangle. The channel compares its direction bits with the destination's direction bits. The result selects one of four traversals: a straight copy, a horizontal flip, a vertical flip or a 180° turn.

The channel counts the pixels the destination takes through a consumer strobe. Underflow means the destination wants more pixels than the channel holds. Overflow means pixels are left over when the destination finishes. Either case is reported in a sticky flag. A second operation can be queued while one runs. If the queued operation has its prefetch bit set, the channel starts issuing its reads once the running operation has issued all of its own reads. These early reads go out at low priority and only when the bus is idle. No read-after-write hazard check is made.

There are two more modes. In host mode, pixels arrive on a host write port and no memory reads are made. In vector mode, the channel only produces byte-enable masks from a programmed pattern and no pixel data.

The controller is a state machine with these states:
- `ST_IDLE`: no operation is active.
- `ST_FETCH`: memory reads are being issued.
- `ST_DRAIN`: all reads are issued and the channel waits for the consumer; prefetch happens here.
- `ST_HOST`: host mode.
- `ST_HSTALL`: host mode after its pixel count has run out.
- `ST_VEC`: vector mode.

The transitions are:
- **start**: `ST_IDLE` to the entry state, which is `ST_FETCH`, `ST_HOST` or `ST_VEC` according to the mode.
- **issued**: `ST_FETCH` to `ST_DRAIN`, when the walker is exhausted.
- **starve**: `ST_HOST` to `ST_HSTALL`, when the host pixel count is used up before the destination is done.
- **finish**: any busy state to `ST_IDLE`, or straight to the queued operation's entry state if one is queued.

Top module: `fc_fetch_chan`

## Requirements
- R1: Register writes go to a staging copy. `cfg_sel` selects the register:
  - 0: width in bits [7:0], height in bits [23:16].
  - 1: mode bits. Bit 0 is the channel X direction, bit 1 the Y direction, bit 2 host mode, bit 3 steer to the pattern path, bit 4 vector mode, bit 19 prefetch enable.
  - 2: base address.
  - 3: destination pixel count in bits [15:0], destination X direction in bit 30, destination Y direction in bit 31.
  - 4: vector pattern.
  
  A pulse on `op_go` copies the staging copy into the active operation when idle, or into the single queued slot when busy. Staging writes made later do not change a running operation.
- R2: `trav_kind` equals {Y direction XOR destination Y direction, X direction XOR destination X direction}. The codes are 00 copy, 01 horizontal flip, 10 vertical flip and 11 180° turn. A flipped axis starts at its far end.
- R3: Outside host and vector modes, the channel issues exactly width×height reads when it runs to the end. It issues one per granted cycle, in row-major order along the traversal. Each address is base + row×width + column.
- R4: When the destination count is reached while the channel still has pixels, the operation ends, `op_done` pulses, `flag_over` is set, and the remaining reads are never issued.
- R5: Outside host mode, when the channel's pixel count is reached before the destination count, the operation ends at once with `op_done` and `flag_under` set.
- R6: In host mode, no memory reads are made, pixels come from the host port, and running out of pixels sets `flag_under` without ending the operation. The operation ends when the destination count is reached.
- R7: A channel rectangle with width and height swapped relative to the destination completes with no flag when the pixel totals match.
- R8: `op_done` is a one-cycle pulse at completion. The flags stay set until the next operation starts.
- R9: A queued operation with the prefetch bit set may issue reads while the active one is in `ST_DRAIN`. It does so only when `bus_idle` is high, and those requests carry `mem_low_pri`.
- R10: Reads prefetched for a queued operation count towards it, so that operation issues width×height reads in total.
- R11: Valid pixels go out on `pix_pat_v` when the steer bit is set and on `pix_src_v` otherwise, never on both.
- R12: In vector mode, no reads are made and no pixel is valid. `pix_be` is all ones when pattern bit k is 1 and all zeros when it is 0, where k is the number of pixels taken so far modulo 32. Outside vector mode, `pix_be` is all ones.
- R13: After reset, there is no request, no done pulse, no flag, `host_wready` is low and `pix_be` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Staging register write strobe |
| cfg_sel | input | 3 | Staging register select |
| cfg_wdata | input | 32 | Staging register write data |
| op_go | input | 1 | Start or queue the staged operation |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Pixel address of the request |
| mem_low_pri | output | 1 | Request is a low-priority prefetch |
| mem_gnt | input | 1 | Request accepted this cycle |
| bus_idle | input | 1 | Bus has no other traffic |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| host_wvalid | input | 1 | Host pixel valid |
| host_wdata | input | DATA_W | Host pixel |
| host_wready | output | 1 | Host port accepting (host mode) |
| dst_take | input | 1 | Consumer took one pixel |
| pix_src_v | output | 1 | Pixel valid on the source path |
| pix_pat_v | output | 1 | Pixel valid on the pattern path |
| pix_data | output | DATA_W | Pixel data |
| pix_be | output | DATA_W/8 | Byte-enable mask |
| trav_kind | output | 2 | Traversal code of the active operation |
| op_done | output | 1 | Completion pulse |
| flag_under | output | 1 | Sticky underflow flag |
| flag_over | output | 1 | Sticky overflow flag |

## Verification
The properties assume the following about the inputs:
- A non-zero destination count and a non-zero rectangle.
- `dst_take` raised only while an operation is active.
- `mem_gnt` relevant only while a request is raised.

The stimulus always programs counts of one or more. It raises the consumer strobe only between the start and the observed done pulse. It holds the grant high, so every request is accepted in the cycle it appears. Host and memory data valid are driven only in the tests for those modes.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DRAIN, ST_HOST, ST_HSTALL, ST_VEC
    } fc_state_e;

    localparam logic [2:0] SEL_DIM  = 3'd0;
    localparam logic [2:0] SEL_MODE = 3'd1;
    localparam logic [2:0] SEL_BASE = 3'd2;
    localparam logic [2:0] SEL_DST  = 3'd3;
    localparam logic [2:0] SEL_VPAT = 3'd4;

    localparam int MB_XDIR = 0;
    localparam int MB_YDIR = 1;
    localparam int MB_HOST = 2;
    localparam int MB_PAT  = 3;
    localparam int MB_VEC  = 4;
    localparam int MB_PREF = 19;
    localparam int DB_XDIR = 30;
    localparam int DB_YDIR = 31;
    localparam int HGT_LSB = 16;
endpackage

// File: rtl/fc_walker.sv
module fc_walker #(
    parameter int DIM_W  = 8,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DIM_W-1:0]  ld_w,
    input  logic [DIM_W-1:0]  ld_h,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic              ld_fx,
    input  logic              ld_fy,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              exhausted
);
    localparam int LW = 2 * DIM_W;

    logic [DIM_W-1:0]  w_q, h_q, x_q, y_q, col, row;
    logic [ADDR_W-1:0] base_q;
    logic              fx_q, fy_q, exh_q;
    logic [LW-1:0]     lin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0; h_q <= '0; x_q <= '0; y_q <= '0;
            base_q <= '0; fx_q <= 1'b0; fy_q <= 1'b0; exh_q <= 1'b1;
        end else if (load) begin
            w_q <= ld_w; h_q <= ld_h; base_q <= ld_base;
            fx_q <= ld_fx; fy_q <= ld_fy;
            x_q <= '0; y_q <= '0;
            exh_q <= (ld_w == '0) || (ld_h == '0);
        end else if (step && !exh_q) begin
            if (x_q == w_q - 1'b1) begin
                x_q <= '0;
                if (y_q == h_q - 1'b1) exh_q <= 1'b1;
                else                   y_q <= y_q + 1'b1;
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    always_comb begin
        col  = fx_q ? (w_q - 1'b1 - x_q) : x_q;
        row  = fy_q ? (h_q - 1'b1 - y_q) : y_q;
        lin  = LW'(row) * LW'(w_q) + LW'(col);
        addr = base_q + ADDR_W'(lin);
    end

    assign exhausted = exh_q;
endmodule

// File: rtl/fc_tally.sv
module fc_tally #(
    parameter int DIM_W = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [DIM_W-1:0] chan_w,
    input  logic [DIM_W-1:0] chan_h,
    input  logic [CNT_W-1:0] dst_cnt,
    output logic [CNT_W-1:0] consumed,
    output logic             end_dst,
    output logic             hit_chan,
    output logic             chan_more
);
    localparam int LW = 2 * DIM_W;

    logic [CNT_W-1:0] chan_total, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    consumed <= '0;
        else if (clr)  consumed <= '0;
        else if (take) consumed <= cnt_nx;
    end

    always_comb begin
        chan_total = CNT_W'(LW'(chan_w) * LW'(chan_h));
        cnt_nx     = consumed + 1'b1;
        end_dst    = take && (cnt_nx == dst_cnt);
        hit_chan   = take && (cnt_nx == chan_total) && (chan_total < dst_cnt);
        chan_more  = chan_total > dst_cnt;
    end
endmodule

// File: rtl/fc_fetch_chan.sv
module fc_fetch_chan
    import fc_pkg::*;
#(
    parameter int DIM_W  = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [31:0]         cfg_wdata,
    input  logic                op_go,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_low_pri,
    input  logic                mem_gnt,
    input  logic                bus_idle,
    input  logic                mem_rvalid,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                host_wvalid,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic                host_wready,
    input  logic                dst_take,
    output logic                pix_src_v,
    output logic                pix_pat_v,
    output logic [DATA_W-1:0]   pix_data,
    output logic [DATA_W/8-1:0] pix_be,
    output logic [1:0]          trav_kind,
    output logic                op_done,
    output logic                flag_under,
    output logic                flag_over
);
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        logic [DIM_W-1:0]  w;
        logic [DIM_W-1:0]  h;
        logic [ADDR_W-1:0] base;
        logic              xd, yd, host, pat, vec, pref, dxd, dyd;
        logic [CNT_W-1:0]  dcnt;
        logic [31:0]       vpat;
    } op_t;

    function automatic fc_state_e entry_state(input op_t o);
        if (o.host)     return ST_HOST;
        else if (o.vec) return ST_VEC;
        else            return ST_FETCH;
    endfunction

    fc_state_e state, state_nx;
    op_t stage, pend, act, nxt_op, wk_src;
    logic pend_v, pre_own, busy, tk, op_end, act_now, pend_take, go_q;
    logic pre_load, wk_load, wk_step, wk_exh, host_st, pix_v;
    logic set_u, set_o, clr_f;
    logic [CNT_W-1:0] consumed;
    logic end_dst, hit_chan, chan_more;

    // staging registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_DIM: begin
                    stage.w <= cfg_wdata[DIM_W-1:0];
                    stage.h <= cfg_wdata[HGT_LSB +: DIM_W];
                end
                SEL_MODE: begin
                    stage.xd   <= cfg_wdata[MB_XDIR];
                    stage.yd   <= cfg_wdata[MB_YDIR];
                    stage.host <= cfg_wdata[MB_HOST];
                    stage.pat  <= cfg_wdata[MB_PAT];
                    stage.vec  <= cfg_wdata[MB_VEC];
                    stage.pref <= cfg_wdata[MB_PREF];
                end
                SEL_BASE: stage.base <= cfg_wdata[ADDR_W-1:0];
                SEL_DST: begin
                    stage.dcnt <= cfg_wdata[CNT_W-1:0];
                    stage.dxd  <= cfg_wdata[DB_XDIR];
                    stage.dyd  <= cfg_wdata[DB_YDIR];
                end
                SEL_VPAT: stage.vpat <= cfg_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        tk        = dst_take && busy;
        op_end    = busy && (end_dst || (hit_chan && !act.host && !act.vec));
        act_now   = (!busy && (op_go || pend_v)) || (op_end && pend_v);
        pend_take = act_now && (busy || pend_v);
        go_q      = op_go && (busy || pend_v) && (!pend_v || pend_take);
        nxt_op    = (!busy && !pend_v) ? stage : pend;
        pre_load  = (state == ST_DRAIN) && pend_v && pend.pref && !pend.host
                    && !pend.vec && !pre_own && !op_end;
        wk_load   = pre_load || (act_now && !(busy && pre_own));
        wk_src    = pre_load ? pend : nxt_op;
        host_st   = (state == ST_HOST) || (state == ST_HSTALL);
        set_u     = busy && hit_chan && !act.vec;
        set_o     = busy && end_dst && chan_more && !act.vec;
        clr_f     = (!busy && act_now) || (op_done && busy);
    end

    // queued slot, active copy, prefetch ownership
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0; pend_v <= 1'b0; act <= '0; pre_own <= 1'b0;
        end else begin
            if (go_q) begin
                pend <= stage; pend_v <= 1'b1;
            end else if (pend_take) begin
                pend_v <= 1'b0;
            end
            if (act_now) act <= nxt_op;
            if (act_now)       pre_own <= 1'b0;
            else if (pre_load) pre_own <= 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (act_now) state_nx = entry_state(nxt_op);
            ST_FETCH:  if (wk_exh)  state_nx = ST_DRAIN;
            ST_HOST:   if (hit_chan) state_nx = ST_HSTALL;
            ST_DRAIN, ST_HSTALL, ST_VEC: ;
            default:   state_nx = ST_IDLE;
        endcase
        if (op_end) state_nx = pend_v ? entry_state(pend) : ST_IDLE;
    end

    // outputs
    always_comb begin
        mem_req     = ((state == ST_FETCH) && !wk_exh)
                      || ((state == ST_DRAIN) && pre_own && !wk_exh && bus_idle);
        mem_low_pri = (state == ST_DRAIN) && pre_own && mem_req;
        wk_step     = mem_req && mem_gnt;
        host_wready = host_st;
        pix_v       = host_st ? host_wvalid : ((state != ST_VEC) && mem_rvalid);
        pix_data    = host_st ? host_wdata : mem_rdata;
        pix_src_v   = pix_v && !act.pat;
        pix_pat_v   = pix_v && act.pat;
        pix_be      = (state == ST_VEC) ? {BE_W{act.vpat[consumed[4:0]]}} : {BE_W{1'b1}};
        trav_kind   = {act.yd ^ act.dyd, act.xd ^ act.dxd};
    end

    // completion pulse and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_done <= 1'b0; flag_under <= 1'b0; flag_over <= 1'b0;
        end else begin
            op_done <= op_end;
            if (set_u)      flag_under <= 1'b1;
            else if (clr_f) flag_under <= 1'b0;
            if (set_o)      flag_over <= 1'b1;
            else if (clr_f) flag_over <= 1'b0;
        end
    end

    fc_walker #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(wk_load),
        .ld_w(wk_src.w), .ld_h(wk_src.h), .ld_base(wk_src.base),
        .ld_fx(wk_src.xd ^ wk_src.dxd), .ld_fy(wk_src.yd ^ wk_src.dyd),
        .step(wk_step), .addr(mem_addr), .exhausted(wk_exh)
    );

    fc_tally #(.DIM_W(DIM_W), .CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .clr(act_now), .take(tk),
        .chan_w(act.w), .chan_h(act.h), .dst_cnt(act.dcnt),
        .consumed(consumed), .end_dst(end_dst), .hit_chan(hit_chan),
        .chan_more(chan_more)
    );
endmodule

// File: rtl/fc_fetch_chan_chk.sv
module fc_fetch_chan_chk
    import fc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      mem_req,
    input logic      mem_low_pri,
    input logic      bus_idle,
    input logic      op_done,
    input logic      flag_over,
    input logic      pix_src_v,
    input logic      pix_pat_v,
    input logic      host_wready,
    input fc_state_e state
);
    // R9
    low_pri_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_low_pri |-> (mem_req && bus_idle));

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> ($past(state) != ST_IDLE));

    // R4
    over_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_over) |-> op_done);

    // R11
    steer_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_src_v && pix_pat_v));

    // R12
    vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VEC) |-> (!mem_req && !pix_src_v && !pix_pat_v));

    // R6
    host_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wready |-> !mem_req);
endmodule

bind fc_fetch_chan fc_fetch_chan_chk u_chk (.*);

// File: tb/test_fc_fetch_chan.sv
module test_fc_fetch_chan;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, op_go = 1'b0, mem_gnt = 1'b1, bus_idle = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0, mem_rdata = '0, host_wdata = '0, pix_data;
    logic mem_rvalid = 1'b0, host_wvalid = 1'b0, dst_take = 1'b0;
    logic mem_req, mem_low_pri, host_wready, pix_src_v, pix_pat_v;
    logic op_done, flag_under, flag_over;
    logic [23:0] mem_addr;
    logic [3:0] pix_be;
    logic [1:0] trav_kind;

    int checks = 0, errors = 0, nreq = 0, nlow = 0, nb = 0, nt = 0;
    logic [23:0] addrs [2];
    logic [23:0] low_a0;

    always #(CLK_P/2) clk = ~clk;

    fc_fetch_chan i_fc_fetch_chan (.*);

    typedef struct packed {
        logic [7:0] w, h;
        logic xd, yd, dxd, dyd;
        logic [15:0] dcnt;
        logic eu, eo;
        logic [23:0] a0, a1;
        logic [1:0] tk;
    } vec_t;

    localparam vec_t TBL [7] = '{
        '{8'd4, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'd12, 1'b0, 1'b0, 24'd100, 24'd101, 2'd0},
        '{8'd4, 8'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'd12, 1'b0, 1'b0, 24'd103, 24'd102, 2'd1},
        '{8'd4, 8'd3, 1'b1, 1'b1, 1'b1, 1'b0, 16'd12, 1'b0, 1'b0, 24'd108, 24'd109, 2'd2},
        '{8'd4, 8'd3, 1'b1, 1'b1, 1'b0, 1'b0, 16'd12, 1'b0, 1'b0, 24'd111, 24'd110, 2'd3},
        '{8'd3, 8'd4, 1'b0, 1'b0, 1'b0, 1'b0, 16'd12, 1'b0, 1'b0, 24'd100, 24'd101, 2'd0},
        '{8'd4, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0, 16'd12, 1'b0, 1'b1, 24'd100, 24'd101, 2'd0},
        '{8'd3, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10, 1'b1, 1'b0, 24'd100, 24'd101, 2'd0}
    };

    // request monitor, sampled after inputs settle
    always begin
        @(negedge clk); #1;
        if (mem_req && mem_gnt) begin
            if (nreq < 2) addrs[nreq] = mem_addr;
            nreq++;
            if (mem_low_pri) begin
                if (nlow == 0) low_a0 = mem_addr;
                nlow++;
            end
            if (mem_addr >= 24'd200) nb++;
        end
    end

    task automatic chk(input bit ok, input string req, input int actv, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic prog(input int w, input int h, input logic [31:0] mode,
                        input int base, input int dcnt, input bit dx, input bit dy);
        wr(3'd0, 32'(w) | (32'(h) << 16));
        wr(3'd1, mode);
        wr(3'd2, 32'(base));
        wr(3'd3, 32'(dcnt) | (32'(dx) << 30) | (32'(dy) << 31));
    endtask

    task automatic go();
        @(negedge clk); op_go = 1'b1;
        @(negedge clk); op_go = 1'b0;
    endtask

    task automatic run_takes(input bit hv);
        nt = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (op_done) break;
            dst_take = 1'b1; host_wvalid = hv; nt++;
        end
        dst_take = 1'b0; host_wvalid = 1'b0;
    endtask

    task automatic clr_mon();
        @(negedge clk); nreq = 0; nlow = 0; nb = 0;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(!mem_req && !op_done && !flag_under && !flag_over && !host_wready,
            "R13 idle outputs", int'(mem_req), 0);
        chk(pix_be == 4'hF, "R13 pix_be", int'(pix_be), 15);

        // table: R2 R3 R4 R5 R7
        for (int k = 0; k < 7; k++) begin
            clr_mon();
            prog(TBL[k].w, TBL[k].h, {30'd0, TBL[k].yd, TBL[k].xd}, 100,
                 TBL[k].dcnt, TBL[k].dxd, TBL[k].dyd);
            go();
            run_takes(1'b0);
            chk(flag_under == TBL[k].eu, "R5 underflow flag", int'(flag_under), int'(TBL[k].eu));
            chk(flag_over == TBL[k].eo, "R4 overflow flag", int'(flag_over), int'(TBL[k].eo));
            chk(trav_kind == TBL[k].tk, "R2 trav_kind", int'(trav_kind), int'(TBL[k].tk));
            chk(nt == (TBL[k].eu ? TBL[k].w * TBL[k].h : int'(TBL[k].dcnt)),
                "R5 takes to end", nt, int'(TBL[k].dcnt));
            repeat (2) @(negedge clk);
            chk(addrs[0] == TBL[k].a0, "R2 first addr", int'(addrs[0]), int'(TBL[k].a0));
            chk(addrs[1] == TBL[k].a1, "R3 second addr", int'(addrs[1]), int'(TBL[k].a1));
            if (TBL[k].eo)
                chk(nreq < TBL[k].w * TBL[k].h, "R4 discard", nreq, TBL[k].w * TBL[k].h);
            else
                chk(nreq == TBL[k].w * TBL[k].h, "R3 R7 read count", nreq, TBL[k].w * TBL[k].h);
        end

        // R8 sticky, then cleared by next start; done is one pulse
        @(negedge clk);
        chk(flag_under && !op_done, "R8 sticky under", int'(flag_under), 1);
        prog(2, 2, 32'd0, 100, 4, 1'b0, 1'b0);
        go();
        chk(!flag_under, "R8 cleared on start", int'(flag_under), 0);
        run_takes(1'b0);
        @(negedge clk);
        chk(!op_done, "R8 done one cycle", int'(op_done), 0);

        // R6 host mode
        clr_mon();
        prog(2, 2, 32'h4, 100, 6, 1'b0, 1'b0);
        host_wdata = 32'h1234;
        go();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 1) chk(pix_src_v && host_wready && pix_data == 32'h1234,
                            "R6 host pixel", int'(pix_src_v), 1);
            if (i == 4) chk(flag_under && !op_done, "R6 underflow stall",
                            int'(op_done), 0);
            dst_take = 1'b1; host_wvalid = 1'b1;
        end
        @(negedge clk);
        dst_take = 1'b0; host_wvalid = 1'b0;
        chk(op_done && flag_under, "R6 host end", int'(op_done), 1);
        chk(nreq == 0, "R6 no reads", nreq, 0);

        // R12 vector mode
        clr_mon();
        wr(3'd4, 32'h5);
        prog(2, 2, 32'h10, 100, 4, 1'b0, 1'b0);
        go();
        for (int i = 0; i < 4; i++) begin
            chk(pix_be == ((i % 2 == 0) ? 4'hF : 4'h0), "R12 be mask", int'(pix_be),
                (i % 2 == 0) ? 15 : 0);
            dst_take = 1'b1;
            @(negedge clk);
        end
        dst_take = 1'b0;
        chk(op_done, "R12 vector done", int'(op_done), 1);
        chk(nreq == 0, "R12 no reads", nreq, 0);

        // R11 steer to pattern path
        prog(2, 2, 32'h8, 100, 4, 1'b0, 1'b0);
        mem_rvalid = 1'b1; mem_rdata = 32'hA5A50001;
        go();
        chk(pix_pat_v && !pix_src_v && pix_data == 32'hA5A50001, "R11 steer",
            int'(pix_pat_v), 1);
        run_takes(1'b0);
        mem_rvalid = 1'b0;

        // R9 R10 R1 prefetch of a queued operation
        clr_mon();
        prog(2, 2, 32'd0, 100, 4, 1'b0, 1'b0);
        go();
        prog(2, 2, 32'h80000, 200, 4, 1'b0, 1'b0);
        go();
        repeat (6) @(negedge clk);
        chk(nlow == 0 && nreq == 4, "R9 no prefetch while bus busy", nlow, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); bus_idle = 1'b1;
        end
        @(negedge clk); bus_idle = 1'b0;
        run_takes(1'b0);
        chk(!flag_under && !flag_over && nt == 4, "R1 active unaffected", nt, 4);
        run_takes(1'b0);
        repeat (2) @(negedge clk);
        chk(nlow == 3, "R9 low priority reads", nlow, 3);
        chk(low_a0 == 24'd200, "R9 prefetch addr", int'(low_a0), 200);
        chk(nb == 4 && nreq == 8, "R10 prefetched counted", nb, 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule